// File: doc/BRIEF.md
# Cache Word Error Protection with Poison Propagation

This block sits between a cache controller and one cache data array. It protects each 64-bit word. On the write side it turns a data word and a poison marker into a stored codeword. On the read side it takes the raw codeword that the array returns and produces a checked word with error flags.

A build parameter picks one of two protection levels:

- **Correcting level.** Used for arrays that may hold modified (dirty) data. It stores a 72-bit Hamming code with an extra overall parity bit. This corrects any one flipped bit and detects any two.
- **Detecting level.** Used for arrays that only ever hold clean copies. It stores one even-parity bit per word. A mismatch asks the requester to fetch the line again.

In both levels the poison marker is stored as two copies outside the code. A poisoned word travels onward flagged, instead of raising a fault at once.

The block also keeps error logs that software can read:

- a saturating count of corrected events;
- a saturating count of uncorrected events;
- a capture of the address of the first uncorrected event.

Software reads these through a small select/clear register port. A single hard-failed bit in a word is corrected again on every read, so such a word stays usable.

Both data paths use valid/ready handshakes:

- **Write path.** It is combinational. The encoded word is offered on the array side in the same cycle, and back-pressure from the array passes straight to the writer.
- **Read path.** It has one output register. A beat is accepted when the register is empty or is being drained in the same cycle. While `rd_valid` is high and `rd_ready` is low, the register holds the beat unchanged and no new beat is accepted.

Top module: `cache_word_guard`

## Requirements
- R1: In correcting mode, `enc_code` is laid out as follows:
  - `enc_code[71:0]` is a Hamming word by position index p.
  - Check bits sit at p = 1, 2, 4, 8, 16, 32 and 64. Each is chosen so that the XOR of all indices p (1..71) whose bit is 1 equals zero.
  - Data bits 0..63 fill the remaining positions 3..71 in ascending order.
  - Bit 0 makes the XOR of all 72 bits zero.
  - `enc_code[73:72]` are both equal to `wr_poison`.
  - `enc_valid` follows `wr_valid`, and `wr_ready` follows `enc_ready`, in the same cycle.
- R2: A read beat with no flipped bits appears on the `rd_*` outputs in the cycle after it is accepted. It carries the original data with `rd_corrected`, `rd_uncorr` and `rd_refetch` all 0.
- R3: In correcting mode, a beat with exactly one flipped bit among positions 0..71 returns the original data with `rd_corrected`=1 and `rd_uncorr`=0.
- R4: In correcting mode, a beat with exactly two flipped bits among positions 0..71 gives `rd_uncorr`=1 and `rd_poison`=1. The data is the uncorrected content of the data positions.
- R5: `rd_poison` is 1 whenever either stored poison copy (bit 72 or 73 in correcting mode) is 1. A poisoned word that has no code error adds to no counter.
- R6: In detecting mode, the code layout is:
  - `enc_code[63:0]` holds the data;
  - `enc_code[64]` is the even parity of the data;
  - `enc_code[66:65]` both hold the poison marker.

  On a read, an odd count of flipped bits in [64:0] gives `rd_refetch`=1, leaves the data raw, and does not by itself poison the word. An even count is not seen.
- R7: While `rd_valid`=1 and `rd_ready`=0, `fill_ready` is 0 and every `rd_*` output holds its value. Otherwise `fill_ready` is 1.
- R8: Each accepted corrected beat adds one to the corrected count. Each accepted beat with `rd_uncorr` or `rd_refetch` adds one to the uncorrected count. Both counts stop at 2^CNT_W-1 (255 by default).
- R9: `csr_rdata` returns the following, and all three are zero after reset:

  | `csr_sel` | Returned value |
  |-----------|----------------|
  | 0 | corrected count |
  | 1 | uncorrected count |
  | 2 | capture: bit 31 = valid, address in the low bits |
  | 3 | zero |

  Pulsing `csr_clr` with `csr_sel` = 0, 1 or 2 zeroes that register at the next edge. The clear wins over an event in the same cycle.
- R10: The first uncorrected event after reset or after a capture clear latches `fill_addr` into the capture register and sets its valid bit. Later events leave the capture unchanged until it is cleared.
- R11: The same word read again and again with the same single hard-faulted bit is corrected on every read and counted on every read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken (follows enc_ready) |
| wr_data | input | 64 | Word to protect |
| wr_poison | input | 1 | Poison marker of the word |
| enc_valid | output | 1 | Codeword offered to the array |
| enc_ready | input | 1 | Array takes the codeword |
| enc_code | output | CODE_W (74 or 67) | Stored codeword |
| fill_valid | input | 1 | Raw codeword from the array offered |
| fill_ready | output | 1 | Raw codeword accepted |
| fill_code | input | CODE_W | Raw codeword read from the array |
| fill_addr | input | ADDR_W | Address of the read word, for capture |
| rd_valid | output | 1 | Checked word available |
| rd_ready | input | 1 | Consumer takes the checked word |
| rd_data | output | 64 | Checked (corrected where possible) data |
| rd_poison | output | 1 | Word is poisoned |
| rd_corrected | output | 1 | One bit was corrected |
| rd_uncorr | output | 1 | Double error found (correcting mode) |
| rd_refetch | output | 1 | Parity mismatch, fetch again (detecting mode) |
| csr_sel | input | 2 | Log register select |
| csr_clr | input | 1 | Clear the selected log register |
| csr_rdata | output | 32 | Selected log register value |

## Verification
- **Syndrome or correction fault.** The word comes out wrong, with wrong flags, in the very cycle after acceptance. This shows up across sweeps of a single flip over all 72 positions and of double flips that include check positions.
- **Output register fault.** A register that loses or overwrites a beat under back-pressure shows changed `rd_*` values while `rd_ready` is low. It also shows `fill_ready` high when it should be low.
- **Log state fault.** A counter that wraps or misses an increment, or a capture that is overwritten, shows on `csr_rdata` one cycle after the offending beat is accepted. The bench compares the selected log register on every clock.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int WORD_W = 64;
  localparam int HAM_W  = 72;
  localparam int SYN_W  = 7;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              poison;
    logic              corrected;
    logic              uncorr;
    logic              refetch;
  } rd_beat_t;

  function automatic int code_width(bit secded);
    return secded ? HAM_W + 2 : WORD_W + 3;
  endfunction

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // XOR of the indices of every set bit, index 0 excluded
  function automatic logic [SYN_W-1:0] ham_syndrome(logic [HAM_W-1:0] cw);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p < HAM_W; p++)
      if (cw[p]) s ^= SYN_W'(p);
    return s;
  endfunction

  function automatic logic [HAM_W-1:0] ham_place(logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < HAM_W; p++)
      if (!is_pow2(p)) begin
        cw[p] = d[k];
        k++;
      end
    return cw;
  endfunction

  function automatic logic [WORD_W-1:0] ham_extract(logic [HAM_W-1:0] cw);
    logic [WORD_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < HAM_W; p++)
      if (!is_pow2(p)) begin
        d[k] = cw[p];
        k++;
      end
    return d;
  endfunction
endpackage

// File: rtl/cwg_encode.sv
module cwg_encode
  import cwg_pkg::*;
#(
  parameter bit SECDED = 1'b1,
  parameter int CODE_W = 74
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic              poison_i,
  output logic [CODE_W-1:0] code_o
);
  generate
    if (SECDED) begin : g_ham
      logic [HAM_W-1:0] cw;
      logic [SYN_W-1:0] syn;
      always_comb begin
        cw  = ham_place(data_i);
        syn = ham_syndrome(cw);
        for (int j = 0; j < SYN_W; j++) cw[1 << j] = syn[j];
        cw[0] = ^cw[HAM_W-1:1];
      end
      assign code_o = {poison_i, poison_i, cw};
    end else begin : g_par
      assign code_o = {poison_i, poison_i, ^data_i, data_i};
    end
  endgenerate
endmodule

// File: rtl/cwg_decode.sv
module cwg_decode
  import cwg_pkg::*;
#(
  parameter bit SECDED = 1'b1,
  parameter int CODE_W = 74
) (
  input  logic [CODE_W-1:0] code_i,
  output rd_beat_t          beat_o
);
  generate
    if (SECDED) begin : g_ham
      logic [HAM_W-1:0] cw, fixed;
      logic [SYN_W-1:0] syn;
      logic odd, single, dbl;
      always_comb begin
        cw     = code_i[HAM_W-1:0];
        syn    = ham_syndrome(cw);
        odd    = ^cw;
        single = odd && (syn < SYN_W'(HAM_W));
        dbl    = (!odd && (syn != '0)) || (odd && !single);
        fixed  = cw;
        if (single) fixed[syn] = ~fixed[syn];
        beat_o.data      = ham_extract(fixed);
        beat_o.corrected = single;
        beat_o.uncorr    = dbl;
        beat_o.refetch   = 1'b0;
        beat_o.poison    = (|code_i[HAM_W+1:HAM_W]) | dbl;
      end
    end else begin : g_par
      always_comb begin
        beat_o.data      = code_i[WORD_W-1:0];
        beat_o.corrected = 1'b0;
        beat_o.uncorr    = 1'b0;
        beat_o.refetch   = ^code_i[WORD_W:0];
        beat_o.poison    = |code_i[WORD_W+2:WORD_W+1];
      end
    end
  endgenerate
endmodule

// File: rtl/cwg_log.sv
module cwg_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

module cwg_log #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_corr,
  input  logic              evt_uncorr,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [1:0]        csr_sel,
  input  logic              csr_clr,
  output logic [31:0]       csr_rdata,
  output logic [CNT_W-1:0]  cnt_corr,
  output logic [CNT_W-1:0]  cnt_uncorr,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr
);
  localparam int NCNT = 2;
  logic [NCNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic clr_cap;

  assign inc     = {evt_uncorr, evt_corr};
  assign clr_cap = csr_clr && (csr_sel == 2'd2);

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      cwg_satcnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (inc[i]),
        .clr  (csr_clr && (csr_sel == 2'(i))),
        .count(cnt[i])
      );
    end
  endgenerate

  assign cnt_corr   = cnt[0];
  assign cnt_uncorr = cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cap) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
    end else if (evt_uncorr && !cap_valid) begin
      cap_valid <= 1'b1;
      cap_addr  <= evt_addr;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      2'd0: csr_rdata[CNT_W-1:0] = cnt_corr;
      2'd1: csr_rdata[CNT_W-1:0] = cnt_uncorr;
      2'd2: begin
        csr_rdata[ADDR_W-1:0] = cap_addr;
        csr_rdata[31]         = cap_valid;
      end
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cache_word_guard.sv
module cache_word_guard
  import cwg_pkg::*;
#(
  parameter bit SECDED = 1'b1,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int CODE_W = code_width(SECDED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_poison,
  output logic              enc_valid,
  input  logic              enc_ready,
  output logic [CODE_W-1:0] enc_code,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [CODE_W-1:0] fill_code,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_poison,
  output logic              rd_corrected,
  output logic              rd_uncorr,
  output logic              rd_refetch,
  input  logic [1:0]        csr_sel,
  input  logic              csr_clr,
  output logic [31:0]       csr_rdata
);
  rd_beat_t beat_d, beat_q;
  logic accept;
  logic [CNT_W-1:0]  cnt_corr, cnt_uncorr;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;

  assign enc_valid = wr_valid;
  assign wr_ready  = enc_ready;

  cwg_encode #(.SECDED(SECDED), .CODE_W(CODE_W)) u_enc (
    .data_i  (wr_data),
    .poison_i(wr_poison),
    .code_o  (enc_code)
  );

  cwg_decode #(.SECDED(SECDED), .CODE_W(CODE_W)) u_dec (
    .code_i(fill_code),
    .beat_o(beat_d)
  );

  assign fill_ready = !rd_valid || rd_ready;
  assign accept     = fill_valid && fill_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      beat_q   <= '0;
    end else if (accept) begin
      rd_valid <= 1'b1;
      beat_q   <= beat_d;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign rd_data      = beat_q.data;
  assign rd_poison    = beat_q.poison;
  assign rd_corrected = beat_q.corrected;
  assign rd_uncorr    = beat_q.uncorr;
  assign rd_refetch   = beat_q.refetch;

  cwg_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_corr  (accept && beat_d.corrected),
    .evt_uncorr(accept && (beat_d.uncorr || beat_d.refetch)),
    .evt_addr  (fill_addr),
    .csr_sel   (csr_sel),
    .csr_clr   (csr_clr),
    .csr_rdata (csr_rdata),
    .cnt_corr  (cnt_corr),
    .cnt_uncorr(cnt_uncorr),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr)
  );
endmodule

// File: rtl/cwg_guard_chk.sv
module cwg_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [63:0]       rd_data,
  input logic              rd_poison,
  input logic              rd_corrected,
  input logic              rd_uncorr,
  input logic              rd_refetch,
  input logic [1:0]        csr_sel,
  input logic              csr_clr,
  input logic [CNT_W-1:0]  cnt_corr,
  input logic [CNT_W-1:0]  cnt_uncorr,
  input logic              cap_valid,
  input logic [ADDR_W-1:0] cap_addr
);
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_poison)
      && $stable(rd_corrected) && $stable(rd_uncorr) && $stable(rd_refetch)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |-> !fill_ready); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(rd_corrected && rd_uncorr) && !(rd_refetch && (rd_corrected || rd_uncorr))); // R3

  AST_UNCORR_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_uncorr |-> rd_poison); // R4

  AST_CORR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_corr < $past(cnt_corr)) |-> $past(csr_clr && csr_sel == 2'd0)); // R8

  AST_UNCORR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_uncorr < $past(cnt_uncorr)) |-> $past(csr_clr && csr_sel == 2'd1)); // R8

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_valid) && !$past(csr_clr && csr_sel == 2'd2) |->
      cap_valid && cap_addr == $past(cap_addr)); // R10
endmodule

bind cache_word_guard cwg_guard_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cache_word_guard.sv
module tb_cache_word_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // correcting-mode instance
  logic        wr_valid = 0, wr_ready, wr_poison = 0, enc_valid, enc_ready = 1;
  logic [63:0] wr_data = '0;
  logic [73:0] enc_code, fill_code = '0;
  logic        fill_valid = 0, fill_ready, rd_valid, rd_ready = 1;
  logic [15:0] fill_addr = '0;
  logic [63:0] rd_data;
  logic        rd_poison, rd_corrected, rd_uncorr, rd_refetch;
  logic [1:0]  csr_sel = '0;
  logic        csr_clr = 0;
  logic [31:0] csr_rdata;

  cache_word_guard #(.SECDED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_poison(wr_poison), .enc_valid(enc_valid),
    .enc_ready(enc_ready), .enc_code(enc_code), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_code(fill_code), .fill_addr(fill_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_poison(rd_poison), .rd_corrected(rd_corrected), .rd_uncorr(rd_uncorr),
    .rd_refetch(rd_refetch), .csr_sel(csr_sel), .csr_clr(csr_clr),
    .csr_rdata(csr_rdata));

  // detecting-mode instance
  logic        pc_wr_ready, pc_enc_valid, pc_fill_valid = 0, pc_fill_ready, pc_rd_valid;
  logic [63:0] pc_wr_data = '0, pc_rd_data;
  logic        pc_wr_poison = 0;
  logic [66:0] pc_enc_code, pc_fill_code = '0;
  logic [15:0] pc_fill_addr = '0;
  logic        pc_rd_poison, pc_rd_corrected, pc_rd_uncorr, pc_rd_refetch;
  logic [1:0]  pc_csr_sel = '0;
  logic [31:0] pc_csr_rdata;
  logic        one = 1'b1, zero = 1'b0;

  cache_word_guard #(.SECDED(1'b0)) dut_clean (
    .clk(clk), .rst_n(rst_n), .wr_valid(one), .wr_ready(pc_wr_ready),
    .wr_data(pc_wr_data), .wr_poison(pc_wr_poison), .enc_valid(pc_enc_valid),
    .enc_ready(one), .enc_code(pc_enc_code), .fill_valid(pc_fill_valid),
    .fill_ready(pc_fill_ready), .fill_code(pc_fill_code), .fill_addr(pc_fill_addr),
    .rd_valid(pc_rd_valid), .rd_ready(one), .rd_data(pc_rd_data),
    .rd_poison(pc_rd_poison), .rd_corrected(pc_rd_corrected), .rd_uncorr(pc_rd_uncorr),
    .rd_refetch(pc_rd_refetch), .csr_sel(pc_csr_sel), .csr_clr(zero),
    .csr_rdata(pc_csr_rdata));

  int errors = 0, checks = 0, n_ticks = 0;
  bit done = 0;

  // reference model state
  bit m_rv, m_poison, m_corr, m_uncorr, m_cv;
  logic [63:0] m_data;
  logic [15:0] m_ca;
  int m_cc, m_uc;
  string m_tag;
  bit p_poison, p_corr, p_uncorr;
  logic [63:0] p_data;
  logic [15:0] p_addr;
  string p_tag;

  task automatic chk(input bit ok, input string tag, input logic [73:0] act, input logic [73:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [73:0] m_enc(logic [63:0] d, bit p);
    logic [71:0] c;
    int k;
    bit b;
    c = '0;
    k = 0;
    for (int pos = 3; pos < 72; pos++)
      if (!pow2(pos)) begin c[pos] = d[k]; k++; end
    for (int j = 0; j < 7; j++) begin
      b = 0;
      for (int pos = 1; pos < 72; pos++)
        if (((pos >> j) & 1) == 1) b ^= c[pos];
      c[1 << j] = b;
    end
    c[0] = ^c[71:1];
    return {p, p, c};
  endfunction

  function automatic logic [63:0] m_ext(logic [71:0] c);
    logic [63:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 3; pos < 72; pos++)
      if (!pow2(pos)) begin d[k] = c[pos]; k++; end
    return d;
  endfunction

  task automatic tick(output bit acc);
    bit frdy;
    logic [31:0] exp_csr;
    if (!csr_clr) csr_sel = 2'(n_ticks % 3);
    n_ticks++;
    #1;
    frdy = !m_rv || rd_ready;
    chk(fill_ready === frdy, "R7", 74'(fill_ready), 74'(frdy));
    acc = fill_valid && frdy;
    @(posedge clk);
    if (acc) begin
      m_rv = 1; m_data = p_data; m_poison = p_poison; m_corr = p_corr;
      m_uncorr = p_uncorr; m_tag = p_tag;
      if (p_corr && m_cc < CMAX) m_cc++;
      if (p_uncorr) begin
        if (m_uc < CMAX) m_uc++;
        if (!m_cv) begin m_cv = 1; m_ca = p_addr; end
      end
    end else if (rd_ready) m_rv = 0;
    if (csr_clr) begin
      case (csr_sel)
        2'd0: m_cc = 0;
        2'd1: m_uc = 0;
        2'd2: begin m_cv = 0; m_ca = '0; end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(rd_valid === m_rv, "R7", 74'(rd_valid), 74'(m_rv));
    if (m_rv) begin
      chk(rd_data === m_data, m_tag, 74'(rd_data), 74'(m_data));
      chk(rd_poison === m_poison, {m_tag, "/R5"}, 74'(rd_poison), 74'(m_poison));
      chk(rd_corrected === m_corr, {m_tag, "/R3"}, 74'(rd_corrected), 74'(m_corr));
      chk(rd_uncorr === m_uncorr, {m_tag, "/R4"}, 74'(rd_uncorr), 74'(m_uncorr));
      chk(rd_refetch === 1'b0, m_tag, 74'(rd_refetch), 74'(0));
    end
    case (csr_sel)
      2'd0: exp_csr = 32'(m_cc);
      2'd1: exp_csr = 32'(m_uc);
      default: exp_csr = {m_cv, 15'b0, m_ca};
    endcase
    chk(csr_rdata === exp_csr, csr_sel == 2'd2 ? "R10" : "R8", 74'(csr_rdata), 74'(exp_csr));
  endtask

  task automatic prep(input logic [63:0] d, input bit p, input logic [73:0] flip,
                      input logic [15:0] a, input string tag);
    logic [73:0] good;
    int nf;
    good = m_enc(d, p);
    wr_data = d; wr_poison = p; wr_valid = 1;
    #1;
    chk(enc_code === good, "R1", enc_code, good);
    chk(enc_valid === 1'b1 && wr_ready === enc_ready, "R1", 74'(enc_valid), 74'(1));
    nf = $countones(flip[71:0]);
    fill_code = good ^ flip; fill_addr = a; fill_valid = 1;
    p_corr = (nf == 1); p_uncorr = (nf == 2);
    p_data = (nf == 2) ? m_ext(fill_code[71:0]) : d;
    p_poison = (|fill_code[73:72]) || (nf == 2);
    p_addr = a; p_tag = tag;
  endtask

  task automatic send(input logic [63:0] d, input bit p, input logic [73:0] flip,
                      input logic [15:0] a, input string tag);
    bit acc;
    prep(d, p, flip, a, tag);
    acc = 0;
    while (!acc) tick(acc);
    fill_valid = 0; wr_valid = 0;
  endtask

  task automatic idle(input int n);
    bit acc;
    repeat (n) tick(acc);
  endtask

  task automatic clear_reg(input logic [1:0] sel);
    bit acc;
    csr_sel = sel; csr_clr = 1;
    tick(acc);
    csr_clr = 0;
    #1 chk(csr_rdata === 32'd0, "R9", 74'(csr_rdata), 74'(0));
  endtask

  task automatic pc_read(input logic [66:0] code, input logic [15:0] a, input logic [63:0] ed,
                         input bit ep, input bit er, input string tag);
    pc_fill_code = code; pc_fill_addr = a; pc_fill_valid = 1;
    @(negedge clk);
    pc_fill_valid = 0;
    #1;
    chk(pc_rd_valid === 1'b1, tag, 74'(pc_rd_valid), 74'(1));
    chk(pc_rd_data === ed, tag, 74'(pc_rd_data), 74'(ed));
    chk(pc_rd_poison === ep, {tag, "/R5"}, 74'(pc_rd_poison), 74'(ep));
    chk(pc_rd_refetch === er, tag, 74'(pc_rd_refetch), 74'(er));
    chk(pc_rd_corrected === 1'b0 && pc_rd_uncorr === 1'b0, tag, 74'(pc_rd_uncorr), 74'(0));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] d;
    logic [66:0] pcode;
    bit acc;
    m_rv = 0; m_cc = 0; m_uc = 0; m_cv = 0; m_ca = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk(rd_valid === 1'b0, "R9", 74'(rd_valid), 74'(0));
    for (int s = 0; s < 4; s++) begin
      csr_sel = 2'(s);
      #1 chk(csr_rdata === 32'd0, "R9", 74'(csr_rdata), 74'(0));
    end

    // R2 clean words
    send(64'h0, 0, '0, 16'h10, "R2");
    send('1, 0, '0, 16'h11, "R2");
    send(64'hA5A5_5A5A_F00F_0FF0, 0, '0, 16'h12, "R2");
    for (int i = 0; i < 64; i += 9) send(64'h1 << i, 0, '0, 16'(i), "R2");
    idle(2);

    // R3 single flip at every position
    for (int k = 0; k < 72; k++)
      send({32'(k * 32'h9E37_79B9), 32'(~k)}, 0, 74'(1) << k, 16'(k), "R3");
    idle(2);

    // R4 double flips, including check and overall-parity bits
    send(64'hDEAD_BEEF_0123_4567, 0, (74'(1) << 0) | (74'(1) << 1), 16'h0200, "R4");
    send(64'h0F0F_0F0F_0F0F_0F0F, 0, (74'(1) << 3) | (74'(1) << 71), 16'h0201, "R4");
    send(64'h8000_0000_0000_0001, 0, (74'(1) << 32) | (74'(1) << 64), 16'h0202, "R4");
    idle(3);

    // R5 poison markers
    send(64'h1111_2222_3333_4444, 1, '0, 16'h0300, "R5");
    send(64'h5555_6666_7777_8888, 0, 74'(1) << 72, 16'h0301, "R5");
    send(64'h9999_AAAA_BBBB_CCCC, 1, 74'(1) << 73, 16'h0302, "R5");
    csr_sel = 2'd1;
    #1 chk(csr_rdata === 32'd3, "R5", 74'(csr_rdata), 74'(3));
    idle(3);

    // R7 back-pressure: one beat held, the next stalls
    rd_ready = 0;
    send(64'hCAFE_0000_0000_0001, 0, 74'(1) << 10, 16'h0400, "R7");
    prep(64'hCAFE_0000_0000_0002, 0, '0, 16'h0401, "R7");
    for (int i = 0; i < 3; i++) begin
      tick(acc);
      chk(acc == 0, "R7", 74'(acc), 74'(0));
    end
    rd_ready = 1;
    acc = 0;
    while (!acc) tick(acc);
    fill_valid = 0; wr_valid = 0;
    idle(3);

    // R11 hard fault corrected on each read
    clear_reg(2'd0);
    for (int i = 0; i < 6; i++) send(64'h0BAD_F00D_1234_5678, 0, 74'(1) << 37, 16'h0500, "R11");
    idle(1);
    csr_sel = 2'd0;
    #1 chk(csr_rdata === 32'd6, "R11", 74'(csr_rdata), 74'(6));

    // R10 capture keeps the first address
    clear_reg(2'd2);
    send(64'h1, 0, (74'(1) << 5) | (74'(1) << 6), 16'h1234, "R10");
    send(64'h2, 0, (74'(1) << 9) | (74'(1) << 20), 16'h4321, "R10");
    idle(2);
    csr_sel = 2'd2;
    #1 chk(csr_rdata === {1'b1, 15'b0, 16'h1234}, "R10", 74'(csr_rdata), 74'({1'b1, 15'b0, 16'h1234}));
    clear_reg(2'd2);
    send(64'h3, 0, (74'(1) << 2) | (74'(1) << 40), 16'h0777, "R10");
    idle(1);
    csr_sel = 2'd2;
    #1 chk(csr_rdata === {1'b1, 15'b0, 16'h0777}, "R10", 74'(csr_rdata), 74'({1'b1, 15'b0, 16'h0777}));

    // R8 saturation of the corrected count
    clear_reg(2'd0);
    for (int i = 0; i < 260; i++) begin
      d = {32'(i), 32'(i * 7 + 1)};
      send(d, 0, 74'(1) << (i % 72), 16'(i), "R8");
    end
    idle(1);
    csr_sel = 2'd0;
    #1 chk(csr_rdata === 32'd255, "R8", 74'(csr_rdata), 74'(255));
    clear_reg(2'd0);
    clear_reg(2'd1);
    idle(2);

    // R6 detecting mode
    @(negedge clk);
    d = 64'h0123_4567_89AB_CDEF;
    pc_wr_data = d; pc_wr_poison = 0;
    #1 chk(pc_enc_code === {1'b0, 1'b0, ^d, d}, "R6", 74'(pc_enc_code), 74'({1'b0, 1'b0, ^d, d}));
    pc_wr_poison = 1;
    #1 chk(pc_enc_code === {1'b1, 1'b1, ^d, d}, "R6", 74'(pc_enc_code), 74'({1'b1, 1'b1, ^d, d}));
    @(negedge clk);
    pcode = {2'b00, ^d, d};
    pc_read(pcode, 16'h0010, d, 0, 0, "R2");
    pc_read(pcode ^ (67'(1) << 5), 16'h0A0A, d ^ (64'h1 << 5), 0, 1, "R6");
    pc_read(pcode ^ (67'(1) << 64), 16'h0B0B, d, 0, 1, "R6");
    pc_read(pcode ^ (67'(3) << 7), 16'h0C0C, d ^ (64'h3 << 7), 0, 0, "R6");
    pc_read({2'b11, ^d, d}, 16'h0D0D, d, 1, 0, "R6");
    pc_read({2'b01, ^d, d} ^ (67'(1) << 63), 16'h0E0E, d ^ (64'h1 << 63), 1, 1, "R6");
    pc_csr_sel = 2'd1;
    #1 chk(pc_csr_rdata === 32'd3, "R8", 74'(pc_csr_rdata), 74'(3));
    pc_csr_sel = 2'd2;
    #1 chk(pc_csr_rdata === {1'b1, 15'b0, 16'h0A0A}, "R10", 74'(pc_csr_rdata), 74'({1'b1, 15'b0, 16'h0A0A}));
    pc_csr_sel = 2'd0;
    #1 chk(pc_csr_rdata === 32'd0, "R6", 74'(pc_csr_rdata), 74'(0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule